// File: doc/BRIEF.md
# Scatter-Gather Descriptor Commit Front-End

This block is the bus-facing front end of a scatter-gather DMA dispatcher. Software writes an eight-word descriptor one word at a time through a word-addressed port. The first seven words sit in a staging register. A write to the last word, the control word, with its go bit set places the whole descriptor into a descriptor queue as one entry. Downstream data movers take entries from a pop interface. They report each finished descriptor with a done strobe, and that strobe can also flag an error or an early termination.

A small register window sits beside the descriptor port. It holds a status word, a control word, queue fill levels and sequence numbers. Software uses it to pause or resume hand-out, to enable stopping on faults, to clear sticky flags, and to start a timed internal reset. The reset flushes the queue and clears the staging register.

Top module: `sgd_desc_front`

## Requirements
- R1: After reset the window reads as follows. Status (index 0) has only bit 1 (queue empty) set, plus bit 3 and bit 4, which copy `resp_empty` and `resp_full`. Control (index 1), fill (index 2), index 3 and sequence (index 4) all read 0. `q_valid` and `irq` are 0.
- R2: A descriptor write to word index 0 to 6 only updates staging. A write to index 7 with bit 31 clear does nothing. Neither changes the fill level.
- R3: A write to index 7 with bit 31 set pushes one entry, and the fill level rises on the next cycle. The entry's bits [32*i+31:32*i] hold staged word i for i from 0 to 6, and the top word holds the written control word. Index 2 reports the fill count in both bits 31:16 and bits 15:0.
- R4: Entries leave in commit order. Status bit 2 is set when `DEPTH` entries are held. A commit made while the queue is full is dropped.
- R5: `q_valid` is 1 only when all of these hold: the queue is not empty, no descriptor is in progress, control bits 0 and 5 are clear, status bits 7 and 8 are clear, and no reset is running. A pop marks the head in progress and copies bits 15:0 of its word 3 into index 4 bits 15:0.
- R6: Status bit 0 (busy) is set while the queue is non-empty or a descriptor is in progress. `mv_done` ends the in-progress state and copies that descriptor's sequence number into index 4 bits 31:16.
- R7: Status bit 5 (stopped) is 1 while control bit 0 or control bit 5 is set and no descriptor is in progress.
- R8: A done with `mv_err` while control bit 2 is set sets sticky status bit 7. A done with `mv_early` while control bit 3 is set sets sticky status bit 8. Writing 1 to a sticky bit clears it, and writing 0 leaves it unchanged.
- R9: Sticky status bit 9 is set on a done in any of these cases: the descriptor's control bit 14 is set, `mv_err` is high and control bits 23:16 are non-zero, or `mv_early` is high and control bit 15 is set. Writing 1 clears it. `irq` equals bit 9 AND control bit 4.
- R10: Writing control bit 1 sets status bit 6 for `RESET_CYCLES` cycles. It flushes the queue, zeroes the staging words, and clears the control word, the sticky bits and the sequence numbers. Descriptor writes and window writes made during the reset are ignored.
- R11: Control bits 0, 2, 3, 4 and 5 read back as written. Bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_wr_en | input | 1 | Descriptor word write strobe |
| d_wr_idx | input | 3 | Descriptor word index |
| d_wr_data | input | 32 | Descriptor word data |
| c_addr | input | 3 | Register window word index |
| c_wr_en | input | 1 | Register window write strobe |
| c_wr_data | input | 32 | Register window write data |
| c_rd_data | output | 32 | Register window read data (combinational) |
| q_valid | output | 1 | Head entry available for the movers |
| q_pop | input | 1 | Take the head entry |
| q_desc | output | 256 | Head entry, word i at bits [32*i+31:32*i] |
| mv_done | input | 1 | In-progress descriptor finished |
| mv_err | input | 1 | Finished descriptor had an error |
| mv_early | input | 1 | Finished descriptor ended early |
| resp_empty | input | 1 | Response side empty flag, shown in status |
| resp_full | input | 1 | Response side full flag, shown in status |
| busy | output | 1 | Queue non-empty or descriptor in progress |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle:
- A commit into a full queue leaves the count unchanged.
- Staging-only writes never move the fill level.
- At most one descriptor is handed out at a time, and busy follows every pop.
- A reset request is always followed by the resetting flag.
- Sticky bits persist until a write of 1 clears them.

Other behaviour only the bench's scenarios can show. This covers entry contents and ordering across a full-to-overflow sweep, and the exact length of the reset window. It also covers which combinations of completion, error and early-termination flags raise the interrupt, and that staged words are really zeroed by a reset.

// File: rtl/sgd_front_pkg.sv
`timescale 1ns/1ps
package sgd_front_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned DESC_WORDS = 8;
   localparam int unsigned DESC_BITS  = WORD_W * DESC_WORDS;
   localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
   // word positions inside a descriptor that logic decodes
   localparam int unsigned SEQ_IDX    = 3;
   localparam int unsigned CTRL_IDX   = 7;
   localparam int unsigned GO_BIT     = 31;
   // descriptor control bits used for interrupt qualification
   localparam int unsigned DC_CMPL_IRQ  = 14;
   localparam int unsigned DC_EARLY_IRQ = 15;
   localparam int unsigned DC_ERR_LO    = 16;
   localparam int unsigned DC_ERR_HI    = 23;
   // register window word indices
   localparam int unsigned CSR_STATUS = 0;
   localparam int unsigned CSR_CTRL   = 1;
   localparam int unsigned CSR_FILL   = 2;
   localparam int unsigned CSR_RFILL  = 3;
   localparam int unsigned CSR_SEQ    = 4;
   // status bits
   localparam int unsigned ST_BUSY      = 0;
   localparam int unsigned ST_EMPTY     = 1;
   localparam int unsigned ST_FULL      = 2;
   localparam int unsigned ST_R_EMPTY   = 3;
   localparam int unsigned ST_R_FULL    = 4;
   localparam int unsigned ST_STOPPED   = 5;
   localparam int unsigned ST_RESETTING = 6;
   localparam int unsigned ST_STOP_ERR  = 7;
   localparam int unsigned ST_STOP_ERLY = 8;
   localparam int unsigned ST_IRQ       = 9;
   // control bits
   localparam int unsigned CT_STOP       = 0;
   localparam int unsigned CT_RESET      = 1;
   localparam int unsigned CT_STOP_ERR   = 2;
   localparam int unsigned CT_STOP_ERLY  = 3;
   localparam int unsigned CT_IRQ_EN     = 4;
   localparam int unsigned CT_STOP_FETCH = 5;
   localparam int unsigned CT_W          = 6;

   typedef logic [WORD_W-1:0] word_t;

   // interrupt qualifiers carried with the in-progress descriptor
   typedef struct packed {
      logic err_any;
      logic early_en;
      logic cmpl_en;
   } irq_qual_t;
endpackage

// File: rtl/sgd_stage.sv
`timescale 1ns/1ps
module sgd_stage
   import sgd_front_pkg::*;
#(
   parameter int unsigned NWORDS = DESC_WORDS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  word_t                    wr_data,
   output logic                     commit,
   output logic [NWORDS*WORD_W-1:0] entry
);
   localparam int unsigned     LAST_I = NWORDS - 1;
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(LAST_I);

   // only the final word with its go bit launches the entry
   assign commit = wr_en && (wr_idx == LAST) && wr_data[GO_BIT];

   for (genvar g = 0; g < LAST_I; g++) begin : g_word
      word_t word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                word_q <= '0;
         else if (clear)                            word_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))     word_q <= wr_data;
      end
      assign entry[g*WORD_W +: WORD_W] = word_q;
   end

   // control word bypasses staging so the commit is atomic in one cycle
   assign entry[LAST_I*WORD_W +: WORD_W] = wr_data;
endmodule

// File: rtl/sgd_desc_fifo.sv
`timescale 1ns/1ps
module sgd_desc_fifo #(
   parameter int unsigned WIDTH = 256,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             empty,
   output logic             full
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign dout    = mem[rd_ptr];

   if (DEPTH == (1 << AW)) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_mod
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R4: a commit against a full queue is dropped
   a_r4_drop_when_full : assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == $past(count)));
   // R4: occupancy never exceeds the configured depth
   a_r4_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/sgd_csr.sv
`timescale 1ns/1ps
module sgd_csr
   import sgd_front_pkg::*;
#(
   parameter int unsigned CW           = 4,
   parameter int unsigned RESET_CYCLES = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  c_addr,
   input  logic        c_wr_en,
   input  word_t       c_wr_data,
   input  logic [CW-1:0] fifo_count,
   input  logic        fifo_empty,
   input  logic        fifo_full,
   input  logic        pop_fire,
   input  irq_qual_t   head_qual,
   input  logic [15:0] head_seq,
   input  logic        mv_done,
   input  logic        mv_err,
   input  logic        mv_early,
   input  logic        resp_empty,
   input  logic        resp_full,
   output word_t       c_rd_data,
   output logic        rst_start,
   output logic        resetting,
   output logic        pop_allow,
   output logic        busy,
   output logic        irq
);
   localparam int unsigned RCW = $clog2(RESET_CYCLES + 1);

   logic [RCW-1:0]  rst_cnt_q;
   logic [CT_W-1:0] ctl_q;
   logic            inprog_q, st_err_q, st_early_q, irq_q;
   irq_qual_t       cur_qual_q;
   logic [15:0]     cur_seq_q, rseq_q, wseq_q;
   logic            wr_status, wr_ctl, done_ok, stopped;
   logic            irq_hit;
   logic            unused_wr_bits;

   assign unused_wr_bits = ^{c_wr_data[31:10], c_wr_data[6]};

   assign resetting = (rst_cnt_q != '0);
   assign wr_status = c_wr_en && (c_addr == 3'(CSR_STATUS)) && !resetting;
   assign wr_ctl    = c_wr_en && (c_addr == 3'(CSR_CTRL))   && !resetting;
   assign rst_start = wr_ctl && c_wr_data[CT_RESET];
   assign done_ok   = mv_done && inprog_q && !resetting;

   assign irq_hit = done_ok && (cur_qual_q.cmpl_en ||
                                (mv_err && cur_qual_q.err_any) ||
                                (mv_early && cur_qual_q.early_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_cnt_q  <= '0;
         ctl_q      <= '0;
         inprog_q   <= 1'b0;
         st_err_q   <= 1'b0;
         st_early_q <= 1'b0;
         irq_q      <= 1'b0;
         cur_qual_q <= '0;
         cur_seq_q  <= '0;
         rseq_q     <= '0;
         wseq_q     <= '0;
      end else if (rst_start || resetting) begin
         rst_cnt_q  <= rst_start ? RCW'(RESET_CYCLES) : rst_cnt_q - 1'b1;
         ctl_q      <= '0;
         inprog_q   <= 1'b0;
         st_err_q   <= 1'b0;
         st_early_q <= 1'b0;
         irq_q      <= 1'b0;
         cur_qual_q <= '0;
         cur_seq_q  <= '0;
         rseq_q     <= '0;
         wseq_q     <= '0;
      end else begin
         if (wr_ctl)
            ctl_q <= {c_wr_data[CT_STOP_FETCH:CT_STOP_ERR], 1'b0, c_wr_data[CT_STOP]};
         if (pop_fire) begin
            inprog_q   <= 1'b1;
            cur_qual_q <= head_qual;
            cur_seq_q  <= head_seq;
            rseq_q     <= head_seq;
         end else if (done_ok) begin
            inprog_q <= 1'b0;
            wseq_q   <= cur_seq_q;
         end
         st_err_q   <= (done_ok && mv_err && ctl_q[CT_STOP_ERR]) ||
                       (st_err_q && !(wr_status && c_wr_data[ST_STOP_ERR]));
         st_early_q <= (done_ok && mv_early && ctl_q[CT_STOP_ERLY]) ||
                       (st_early_q && !(wr_status && c_wr_data[ST_STOP_ERLY]));
         irq_q      <= irq_hit || (irq_q && !(wr_status && c_wr_data[ST_IRQ]));
      end
   end

   assign stopped   = (ctl_q[CT_STOP] || ctl_q[CT_STOP_FETCH]) && !inprog_q;
   assign pop_allow = !inprog_q && !ctl_q[CT_STOP] && !ctl_q[CT_STOP_FETCH] &&
                      !st_err_q && !st_early_q && !resetting;
   assign busy      = !fifo_empty || inprog_q;
   assign irq       = irq_q && ctl_q[CT_IRQ_EN];

   always_comb begin
      c_rd_data = '0;
      case (c_addr)
         3'(CSR_STATUS): begin
            c_rd_data[ST_BUSY]      = busy;
            c_rd_data[ST_EMPTY]     = fifo_empty;
            c_rd_data[ST_FULL]      = fifo_full;
            c_rd_data[ST_R_EMPTY]   = resp_empty;
            c_rd_data[ST_R_FULL]    = resp_full;
            c_rd_data[ST_STOPPED]   = stopped;
            c_rd_data[ST_RESETTING] = resetting;
            c_rd_data[ST_STOP_ERR]  = st_err_q;
            c_rd_data[ST_STOP_ERLY] = st_early_q;
            c_rd_data[ST_IRQ]       = irq_q;
         end
         3'(CSR_CTRL):  c_rd_data = {{(WORD_W-CT_W){1'b0}}, ctl_q};
         3'(CSR_FILL):  c_rd_data = {16'(fifo_count), 16'(fifo_count)};
         3'(CSR_RFILL): c_rd_data = '0;
         3'(CSR_SEQ):   c_rd_data = {wseq_q, rseq_q};
         default:       c_rd_data = '0;
      endcase
   end

   // R10: a reset request always opens the resetting window
   a_r10_reset_opens : assert property (@(posedge clk) disable iff (!rst_n)
      rst_start |=> resetting);
   // R8: stop-on-error flag persists until written with one
   a_r8_err_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (st_err_q && !(wr_status && c_wr_data[ST_STOP_ERR]) && !rst_start) |=> st_err_q);
   // R9: pending interrupt persists until written with one
   a_r9_irq_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !(wr_status && c_wr_data[ST_IRQ]) && !rst_start) |=> irq_q);
endmodule

// File: rtl/sgd_desc_front.sv
`timescale 1ns/1ps
module sgd_desc_front
   import sgd_front_pkg::*;
#(
   parameter int unsigned DEPTH        = 8,
   parameter int unsigned RESET_CYCLES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 d_wr_en,
   input  logic [IDX_W-1:0]     d_wr_idx,
   input  logic [WORD_W-1:0]    d_wr_data,
   input  logic [2:0]           c_addr,
   input  logic                 c_wr_en,
   input  logic [WORD_W-1:0]    c_wr_data,
   output logic [WORD_W-1:0]    c_rd_data,
   output logic                 q_valid,
   input  logic                 q_pop,
   output logic [DESC_BITS-1:0] q_desc,
   input  logic                 mv_done,
   input  logic                 mv_err,
   input  logic                 mv_early,
   input  logic                 resp_empty,
   input  logic                 resp_full,
   output logic                 busy,
   output logic                 irq
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
      $error("DEPTH must lie in 2..1024");
   end
   if (RESET_CYCLES < 1 || RESET_CYCLES > 65535) begin : g_bad_rst
      $error("RESET_CYCLES must lie in 1..65535");
   end

   logic                 commit, flush, rst_start, resetting, pop_allow, pop_fire;
   logic                 fifo_empty, fifo_full;
   logic [CW-1:0]        fill;
   logic [DESC_BITS-1:0] staged, head;
   word_t                head_ctl;
   irq_qual_t            head_qual;

   assign flush = rst_start || resetting;

   sgd_stage #(.NWORDS(DESC_WORDS)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (flush),
      .wr_en   (d_wr_en && !flush),
      .wr_idx  (d_wr_idx),
      .wr_data (d_wr_data),
      .commit  (commit),
      .entry   (staged)
   );

   sgd_desc_fifo #(.WIDTH(DESC_BITS), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (commit),
      .pop   (pop_fire),
      .din   (staged),
      .dout  (head),
      .count (fill),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   assign head_ctl           = head[CTRL_IDX*WORD_W +: WORD_W];
   assign head_qual.cmpl_en  = head_ctl[DC_CMPL_IRQ];
   assign head_qual.early_en = head_ctl[DC_EARLY_IRQ];
   assign head_qual.err_any  = |head_ctl[DC_ERR_HI:DC_ERR_LO];

   sgd_csr #(.CW(CW), .RESET_CYCLES(RESET_CYCLES)) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .c_addr     (c_addr),
      .c_wr_en    (c_wr_en),
      .c_wr_data  (c_wr_data),
      .fifo_count (fill),
      .fifo_empty (fifo_empty),
      .fifo_full  (fifo_full),
      .pop_fire   (pop_fire),
      .head_qual  (head_qual),
      .head_seq   (head[SEQ_IDX*WORD_W +: 16]),
      .mv_done    (mv_done),
      .mv_err     (mv_err),
      .mv_early   (mv_early),
      .resp_empty (resp_empty),
      .resp_full  (resp_full),
      .c_rd_data  (c_rd_data),
      .rst_start  (rst_start),
      .resetting  (resetting),
      .pop_allow  (pop_allow),
      .busy       (busy),
      .irq        (irq)
   );

   assign q_valid  = !fifo_empty && pop_allow;
   assign q_desc   = head;
   assign pop_fire = q_valid && q_pop;

   // R2: staging-only writes never alter occupancy
   a_r2_stage_only : assert property (@(posedge clk) disable iff (!rst_n)
      (d_wr_en && d_wr_idx != IDX_W'(CTRL_IDX) && !pop_fire && !flush) |=> (fill == $past(fill)));
   // R5: only one descriptor is handed out at a time
   a_r5_single_inflight : assert property (@(posedge clk) disable iff (!rst_n)
      pop_fire |=> !q_valid);
   // R6: a handed-out descriptor keeps the block busy
   a_r6_busy_after_pop : assert property (@(posedge clk) disable iff (!rst_n)
      pop_fire |=> busy);
endmodule

// File: tb/sgd_desc_front_test.sv
`timescale 1ns/1ps
module sgd_desc_front_test;
   localparam int D  = 4;
   localparam int RC = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         d_wr_en = 1'b0;
   logic [2:0]   d_wr_idx = '0;
   logic [31:0]  d_wr_data = '0;
   logic [2:0]   c_addr = '0;
   logic         c_wr_en = 1'b0;
   logic [31:0]  c_wr_data = '0;
   logic [31:0]  c_rd_data;
   logic         q_valid;
   logic         q_pop = 1'b0;
   logic [255:0] q_desc;
   logic         mv_done = 1'b0, mv_err = 1'b0, mv_early = 1'b0;
   logic         resp_empty = 1'b1, resp_full = 1'b0;
   logic         busy, irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   sgd_desc_front #(.DEPTH(D), .RESET_CYCLES(RC)) uut (
      .clk(clk), .rst_n(rst_n), .d_wr_en(d_wr_en), .d_wr_idx(d_wr_idx),
      .d_wr_data(d_wr_data), .c_addr(c_addr), .c_wr_en(c_wr_en),
      .c_wr_data(c_wr_data), .c_rd_data(c_rd_data), .q_valid(q_valid),
      .q_pop(q_pop), .q_desc(q_desc), .mv_done(mv_done), .mv_err(mv_err),
      .mv_early(mv_early), .resp_empty(resp_empty), .resp_full(resp_full),
      .busy(busy), .irq(irq));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] wgen(input int seed, input int i);
      return (32'(seed) * 32'h0101_0101) ^ (32'(i) << 20) ^ 32'h0000_1357 ^ 32'(i * 7);
   endfunction

   function automatic logic [255:0] exp_desc(input int seed, input logic [31:0] ctl);
      logic [255:0] v;
      for (int i = 0; i < 7; i++) v[i*32 +: 32] = wgen(seed, i);
      v[7*32 +: 32] = ctl | 32'h8000_0000;
      return v;
   endfunction

   task automatic dwr(input int idx, input logic [31:0] v);
      d_wr_en = 1'b1; d_wr_idx = 3'(idx); d_wr_data = v;
      step();
      d_wr_en = 1'b0;
   endtask

   task automatic cwr(input int a, input logic [31:0] v);
      c_wr_en = 1'b1; c_addr = 3'(a); c_wr_data = v;
      step();
      c_wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      c_addr = 3'(a);
      #0.1;
      v = c_rd_data;
   endtask

   task automatic commit(input int seed, input logic [31:0] ctl);
      for (int i = 0; i < 7; i++) dwr(i, wgen(seed, i));
      dwr(7, ctl | 32'h8000_0000);
   endtask

   task automatic popx(input int seed, input logic [31:0] ctl, input string tag);
      check({tag, " q_valid before pop"}, 256'(q_valid), 256'(1));
      check({tag, " entry contents"}, q_desc, exp_desc(seed, ctl));
      q_pop = 1'b1;
      step();
      q_pop = 1'b0;
   endtask

   task automatic finish_desc(input logic e, input logic er);
      mv_done = 1'b1; mv_err = e; mv_early = er;
      step();
      mv_done = 1'b0; mv_err = 1'b0; mv_early = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      rd(0, v); check("R1 status after reset", 256'(v), 256'(32'h0000_000A));
      rd(1, v); check("R1 control after reset", 256'(v), 256'(0));
      rd(2, v); check("R1 fill after reset", 256'(v), 256'(0));
      rd(3, v); check("R1 index 3 reads zero", 256'(v), 256'(0));
      rd(4, v); check("R1 seq after reset", 256'(v), 256'(0));
      check("R1 q_valid after reset", 256'(q_valid), 256'(0));
      check("R1 irq after reset", 256'(irq), 256'(0));
      resp_full = 1'b1; resp_empty = 1'b0;
      rd(0, v); check("R1 response flags mirrored", 256'(v), 256'(32'h0000_0012));
      resp_full = 1'b0; resp_empty = 1'b1;

      // R11 control readback
      cwr(1, 32'h0000_003D);
      rd(1, v); check("R11 control readback", 256'(v), 256'(32'h3D));
      cwr(1, 32'h0);
      rd(1, v); check("R11 control cleared", 256'(v), 256'(0));

      // R2 staging-only writes
      for (int i = 0; i < 7; i++) dwr(i, 32'hFFFF_0000 + 32'(i));
      rd(2, v); check("R2 fill after staging writes", 256'(v), 256'(0));
      dwr(7, 32'h0000_40FF);
      rd(2, v); check("R2 control without go bit", 256'(v), 256'(0));
      check("R2 q_valid stays low", 256'(q_valid), 256'(0));

      // R3 / R4 sweep: fill to full, overflow, drain in order
      for (int n = 1; n <= D; n++) begin
         commit(n, 32'(n));
         rd(2, v); check("R3 fill level after commit", 256'(v), 256'({16'(n), 16'(n)}));
      end
      rd(0, v); check("R4 full flag set", 256'(v[2]), 256'(1));
      commit(99, 32'h0);
      rd(2, v); check("R4 commit while full dropped", 256'(v), 256'({16'(D), 16'(D)}));
      for (int n = 1; n <= D; n++) begin
         popx(n, 32'(n), "R4 ordered drain");
         check("R6 busy while in progress", 256'(busy), 256'(1));
         check("R5 no second hand-out", 256'(q_valid), 256'(0));
         rd(4, v); check("R5 read sequence", 256'(v[15:0]), 256'(wgen(n, 3) & 32'hFFFF));
         finish_desc(1'b0, 1'b0);
         rd(4, v); check("R6 write sequence", 256'(v[31:16]), 256'(wgen(n, 3) & 32'hFFFF));
      end
      rd(0, v); check("R6 idle status after drain", 256'(v), 256'(32'h0000_000A));
      check("R6 busy low when idle", 256'(busy), 256'(0));

      // R7 stop controls
      commit(20, 32'h0);
      cwr(1, 32'h1);
      rd(0, v); check("R7 stopped with queued entry", 256'(v), 256'(32'h29));
      check("R5 stop blocks hand-out", 256'(q_valid), 256'(0));
      cwr(1, 32'h20);
      check("R5 stop-fetch blocks hand-out", 256'(q_valid), 256'(0));
      rd(0, v); check("R7 stop-fetch reports stopped", 256'(v[5]), 256'(1));
      cwr(1, 32'h0);
      popx(20, 32'h0, "R5 resume after stop");
      cwr(1, 32'h1);
      rd(0, v); check("R7 not stopped while in progress", 256'(v), 256'(32'h0B));
      finish_desc(1'b0, 1'b0);
      rd(0, v); check("R7 stopped after done", 256'(v), 256'(32'h2A));
      cwr(1, 32'h0);

      // R8 / R9 sticky error, early and interrupt
      cwr(1, 32'h1C);
      commit(30, 32'h00FF_0000);
      popx(30, 32'h00FF_0000, "R8 error descriptor");
      finish_desc(1'b1, 1'b0);
      rd(0, v); check("R8 stop-on-error sticky and R9 irq", 256'(v), 256'(32'h28A));
      check("R9 irq output asserted", 256'(irq), 256'(1));
      commit(31, 32'h0000_4000);
      check("R5 sticky error blocks hand-out", 256'(q_valid), 256'(0));
      cwr(0, 32'h0);
      rd(0, v); check("R8 write zero keeps sticky", 256'(v), 256'(32'h289));
      cwr(0, 32'h80);
      rd(0, v); check("R8 write one clears error", 256'(v), 256'(32'h209));
      check("R5 hand-out resumes", 256'(q_valid), 256'(1));
      cwr(1, 32'h0C);
      check("R9 irq masked by enable", 256'(irq), 256'(0));
      cwr(0, 32'h200);
      rd(0, v); check("R9 irq cleared", 256'(v), 256'(32'h009));
      cwr(1, 32'h1C);
      popx(31, 32'h0000_4000, "R9 completion descriptor");
      finish_desc(1'b0, 1'b1);
      rd(0, v); check("R8 early sticky and R9 completion irq", 256'(v), 256'(32'h30A));
      cwr(0, 32'h300);
      rd(0, v); check("R8 early and irq cleared", 256'(v), 256'(32'h00A));
      cwr(1, 32'h10);
      commit(32, 32'h0);
      popx(32, 32'h0, "R9 no-qualifier descriptor");
      finish_desc(1'b1, 1'b1);
      rd(0, v); check("R9 no irq without qualifiers; R8 no sticky when disabled", 256'(v), 256'(32'h00A));
      check("R9 irq low", 256'(irq), 256'(0));
      commit(33, 32'h0000_8000);
      popx(33, 32'h0000_8000, "R9 early-irq descriptor");
      finish_desc(1'b0, 1'b1);
      rd(0, v); check("R9 early irq", 256'(v), 256'(32'h20A));
      check("R9 irq output with enable", 256'(irq), 256'(1));
      cwr(0, 32'h200);

      // R10 reset sequence
      commit(40, 32'h0);
      commit(41, 32'h0);
      for (int i = 0; i < 7; i++) dwr(i, wgen(42, i));
      cwr(1, 32'h12);
      rd(0, v); check("R10 resetting flag raised", 256'(v), 256'(32'h4A));
      rd(1, v); check("R10 control cleared", 256'(v), 256'(0));
      rd(2, v); check("R10 queue flushed", 256'(v), 256'(0));
      check("R10 no hand-out during reset", 256'(q_valid), 256'(0));
      dwr(0, 32'h0000_DEAD);
      dwr(7, 32'h8000_0000);
      rd(2, v); check("R10 commit ignored during reset", 256'(v), 256'(0));
      cwr(1, 32'h1);
      repeat (RC - 4) step();
      rd(0, v); check("R10 still resetting at last cycle", 256'(v[6]), 256'(1));
      step();
      rd(0, v); check("R10 reset window ends", 256'(v), 256'(32'h0A));
      rd(1, v); check("R10 control write ignored during reset", 256'(v), 256'(0));
      dwr(7, 32'h8000_0005);
      check("R10 staging zeroed", q_desc, {32'h8000_0005, 224'b0});
      q_pop = 1'b1; step(); q_pop = 1'b0;
      finish_desc(1'b0, 1'b0);
      rd(0, v); check("R10 idle after post-reset descriptor", 256'(v), 256'(32'h0A));

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule